// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block answers like a three-wire serial EEPROM that holds 128 words of 16 bits. Software has no serial port to it. It toggles chip-select, clock and data-in by writing one 8-bit pin register, and it reads data-out back from that same register. Every write to the pin register is one step on the wire. An edge on chip-select or on the clock exists only when one write differs from the one before it.

The pin register is closed until two unlock writes have both landed. One goes to the enable port and one goes to the unlock port. Once it is open, a command starts with a start bit. Ten bits follow: a 2-bit opcode, then an 8-bit field whose low 7 bits address a word. The commands are read, write, erase, write-all, erase-all, write-enable and write-disable. The four opcode-zero commands are told apart by the top two bits of the field.

Top module: `serial_eeprom_resp`

## Requirements
- R1: The access gate has two bits. A write of 0x0A on the enable port sets bit 0. Any other value on the enable port clears both bits, and the enable port wins when both ports are written in the same cycle. A write of 0x40 on the unlock port sets bit 1, and any other value there clears bit 1. Access is open only when both bits are set.
- R2: While access is closed, rdData reads 0xFF and pin-register writes leave the register and the protocol state unchanged.
- R3: Pin register layout: CS is bit 7, CLK is bit 6, DI is bit 1 and DO is bit 0. Other bits read back as written. DO reads 1 whenever it is not driven. After reset the register reads 0x01.
- R4: A write that takes CLK from 1 to 0 while it sets CS to 1 keeps the previous DO value.
- R5: A write that takes CS from 0 to 1 abandons any command in progress and returns to idle.
- R6: In idle, a clock rising edge with DI=1 is the start bit, and a rising edge with DI=0 does nothing. Then 10 bits are taken MSB first on rising edges: opcode[1:0], then an 8-bit field whose bits [6:0] are the word address.
- R7: Opcode 10 (read) drives DO to 0 on the last command edge as a dummy bit. It then drives the stored word MSB first, one bit per rising edge, and returns to idle after 16 bits.
- R8: Opcode 01 (write) takes 16 more data bits MSB first and stores them at the address.
- R9: Opcode 11 (erase) stores 0xFFFF at the address. Opcode 00 with field bits [7:6]=10 (erase-all) stores 0xFFFF in every word. Opcode 00 with [7:6]=01 (write-all) takes 16 data bits and stores them in every word.
- R10: Opcode 00 with [7:6]=11 enables storing and [7:6]=00 disables it. Storing is disabled after reset. While it is disabled, write, erase, write-all and erase-all change nothing.
- R11: After reset every stored word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWr | input | 1 | Write strobe for the enable port (gate bit 0) |
| unlockWr | input | 1 | Write strobe for the unlock port (gate bit 1) |
| pinWr | input | 1 | Write strobe for the pin register |
| wrData | input | 8 | Data for whichever write strobe is high |
| rdData | output | 8 | Pin register read value, or 0xFF while closed |

## Verification
The bench probes the gate with one unlock write missing and with wrong unlock values. A design that opened on either gate bit alone would return the pin register instead of 0xFF. It checks the dummy zero before the read data. A design that skipped it would shift every word left by one bit. It checks that DO holds on a falling clock and is released to 1 on writes with no edge. It sends start-bit-free clocks in idle, which must not start a command. It aborts a half-written word with a chip-select rise, which a design that ignored the abort would commit. It also issues storage commands while storing is disabled, and bulk commands that must touch the first and last word. Random command mixes are scored against a bench-side word model.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int CS_BIT  = 7;
  localparam int CLK_BIT = 6;
  localparam int DI_BIT  = 1;
  localparam int DO_BIT  = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_DOUT, ST_READ, ST_WRITE, ST_ERASE,
    ST_WEN, ST_WDIS, ST_FILL, ST_WIPE
  } state_e;

  typedef enum logic [1:0] {DO_FREE, DO_KEEP, DO_ZERO, DO_MSB} doSel_e;

  typedef struct packed {
    logic   pinLoad;
    logic   clearSr;
    logic   shiftIn;
    logic   shiftOut;
    logic   latchAddr;
    logic   loadWord;
    logic   storeOne;
    logic   storeAll;
    logic   useOnes;
    doSel_e doSel;
  } strobe_t;
endpackage

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [7:0]    wrData,
  output logic [7:0]    pinReg,
  output logic [3:0]    cmdCode
);
  localparam int WORDS    = 1 << ADDR_W;
  localparam int CMD_BITS = ADDR_W + 3;

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] srShift;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrEff;
  logic [DATA_W-1:0] wordIn;
  logic [DATA_W-1:0] mem [WORDS];
  logic              doNext;

  assign srShift = {sr[DATA_W-2:0], wrData[DI_BIT]};
  assign cmdCode = srShift[CMD_BITS-1 -: 4];
  assign addrEff = stb.latchAddr ? srShift[ADDR_W-1:0] : addrReg;
  assign wordIn  = stb.useOnes ? '1 : srShift;

  always_comb begin
    unique case (stb.doSel)
      DO_KEEP: doNext = pinReg[DO_BIT];
      DO_ZERO: doNext = 1'b0;
      DO_MSB:  doNext = sr[DATA_W-1];
      default: doNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr      <= '0;
      addrReg <= '0;
      pinReg  <= 8'h01;
    end else begin
      if (stb.clearSr)       sr <= '0;
      else if (stb.loadWord) sr <= mem[addrEff];
      else if (stb.shiftIn)  sr <= srShift;
      else if (stb.shiftOut) sr <= {sr[DATA_W-2:0], 1'b0};
      if (stb.latchAddr) addrReg <= srShift[ADDR_W-1:0];
      if (stb.pinLoad)   pinReg  <= {wrData[7:1], doNext};
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (!rstN) mem[i] <= '1;
      else if (stb.storeAll || (stb.storeOne && addrEff == ADDR_W'(i)))
        mem[i] <= wordIn;
    end
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWr,
  input  logic       unlockWr,
  input  logic       pinWr,
  input  logic [7:0] wrData,
  input  logic       oldCs,
  input  logic       oldClk,
  input  logic [3:0] cmdCode,
  output strobe_t    stb,
  output logic       gateOpen
);
  localparam int CMD_BITS = ADDR_W + 3;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  logic [1:0]       gate;
  state_e           state, nState, st0, st1;
  logic [CNT_W-1:0] bitCnt, nCnt, cnt1;
  logic             writable, nWen;
  logic             act, csRise, clkRise, clkFall, di;

  function automatic state_e decodeCmd(input logic [3:0] c);
    unique case (c[3:2])
      2'b10:   return ST_READ;
      2'b01:   return ST_WRITE;
      2'b11:   return ST_ERASE;
      default: begin
        unique case (c[1:0])
          2'b00:   return ST_WDIS;
          2'b01:   return ST_FILL;
          2'b10:   return ST_WIPE;
          default: return ST_WEN;
        endcase
      end
    endcase
  endfunction

  assign gateOpen = &gate;
  assign act      = pinWr && gateOpen;
  assign di       = wrData[DI_BIT];
  assign csRise   = !oldCs && wrData[CS_BIT];
  assign clkRise  = !oldClk && wrData[CLK_BIT];
  assign clkFall  = oldClk && !wrData[CLK_BIT] && wrData[CS_BIT];

  always_comb begin
    stb    = '0;
    stb.doSel = DO_FREE;
    nState = state;
    nCnt   = bitCnt;
    nWen   = writable;
    st0    = state;
    st1    = state;
    cnt1   = bitCnt;
    if (act) begin
      stb.pinLoad = 1'b1;
      st0 = csRise ? ST_IDLE : state;
      nState = st0;
      if (clkRise) begin
        if (st0 == ST_CMD || st0 == ST_WRITE || st0 == ST_FILL) begin
          stb.shiftIn = 1'b1;
          cnt1 = bitCnt + 1'b1;
        end
        st1 = st0;
        unique case (st0)
          ST_IDLE: if (di) begin
            st1 = ST_CMD; cnt1 = '0; stb.clearSr = 1'b1;
          end
          ST_CMD: if (cnt1 == CNT_W'(CMD_BITS)) begin
            st1 = decodeCmd(cmdCode); cnt1 = '0; stb.latchAddr = 1'b1;
          end
          ST_DOUT: begin
            stb.doSel = DO_MSB; stb.shiftOut = 1'b1;
            cnt1 = bitCnt - 1'b1;
            if (cnt1 == '0) st1 = ST_IDLE;
          end
          default: ;
        endcase
        unique case (st1)
          ST_WEN:  begin nWen = 1'b1; st1 = ST_IDLE; end
          ST_WDIS: begin nWen = 1'b0; st1 = ST_IDLE; end
          ST_WRITE: if (cnt1 == CNT_W'(DATA_W)) begin
            stb.storeOne = writable; st1 = ST_IDLE;
          end
          ST_ERASE: begin
            stb.storeOne = writable; stb.useOnes = 1'b1; st1 = ST_IDLE;
          end
          ST_READ: begin
            cnt1 = CNT_W'(DATA_W); stb.loadWord = 1'b1;
            stb.doSel = DO_ZERO; st1 = ST_DOUT;
          end
          ST_FILL: if (cnt1 == CNT_W'(DATA_W)) begin
            stb.storeAll = writable; st1 = ST_IDLE;
          end
          ST_WIPE: begin
            stb.storeAll = writable; stb.useOnes = 1'b1; st1 = ST_IDLE;
          end
          default: ;
        endcase
        nState = st1;
        nCnt   = cnt1;
      end else if (clkFall) begin
        stb.doSel = DO_KEEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gate     <= 2'b00;
      state    <= ST_IDLE;
      bitCnt   <= '0;
      writable <= 1'b0;
    end else begin
      if (enWr) gate <= (wrData == 8'h0A) ? {gate[1], 1'b1} : 2'b00;
      else if (unlockWr) gate[1] <= (wrData == 8'h40);
      state    <= nState;
      bitCnt   <= nCnt;
      writable <= nWen;
    end
  end
endmodule

// File: rtl/serial_eeprom_resp.sv
module serial_eeprom_resp
  import eep_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWr,
  input  logic       unlockWr,
  input  logic       pinWr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  strobe_t    stb;
  logic       gateOpen;
  logic [7:0] pinReg;
  logic [3:0] cmdCode;

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enWr(enWr), .unlockWr(unlockWr),
    .pinWr(pinWr), .wrData(wrData), .oldCs(pinReg[CS_BIT]),
    .oldClk(pinReg[CLK_BIT]), .cmdCode(cmdCode), .stb(stb),
    .gateOpen(gateOpen)
  );

  eep_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .pinReg(pinReg), .cmdCode(cmdCode)
  );

  assign rdData = gateOpen ? pinReg : 8'hFF;
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
  input logic       clk,
  input logic       rstN,
  input logic       enWr,
  input logic       unlockWr,
  input logic       pinWr,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       gateOpen,
  input logic [7:0] pinReg
);
  p_enable_close_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && wrData != 8'h0A) |=> (rdData == 8'hFF));

  p_unlock_close_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!enWr && unlockWr && wrData != 8'h40) |=> (rdData == 8'hFF));

  p_closed_ignore_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOpen && pinWr) |=> $stable(pinReg));

  p_do_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gateOpen && pinWr && wrData[6] == pinReg[6]) |=> pinReg[0]);

  p_do_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (gateOpen && pinWr && wrData[7] && pinReg[6] && !wrData[6])
    |=> (pinReg[0] == $past(pinReg[0])));
endmodule

bind serial_eeprom_resp eep_checker chk_i (
  .clk(clk), .rstN(rstN), .enWr(enWr), .unlockWr(unlockWr),
  .pinWr(pinWr), .wrData(wrData), .rdData(rdData),
  .gateOpen(gateOpen), .pinReg(pinReg)
);

// File: tb/serial_eeprom_resp_tb_top.sv
`timescale 1ns/1ps
module serial_eeprom_resp_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enWr = 1'b0, unlockWr = 1'b0, pinWr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [15:0] model [128];
  bit wen = 0;

  serial_eeprom_resp dut_i (
    .clk(clk), .rstN(rstN), .enWr(enWr), .unlockWr(unlockWr),
    .pinWr(pinWr), .wrData(wrData), .rdData(rdData)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input int which, input logic [7:0] v);
    @(negedge clk);
    wrData = v;
    if (which == 0) enWr = 1'b1; else if (which == 1) unlockWr = 1'b1; else pinWr = 1'b1;
    @(negedge clk);
    enWr = 1'b0; unlockWr = 1'b0; pinWr = 1'b0;
  endtask

  task automatic pinw(input logic cs, input logic ck, input logic di, output logic [7:0] rd);
    pulse(2, {cs, ck, 4'b0000, di, 1'b0});
    rd = rdData;
  endtask

  task automatic clockBit(input logic di, output logic dout);
    logic [7:0] rd;
    pinw(1'b1, 1'b0, di, rd);
    pinw(1'b1, 1'b1, di, rd);
    dout = rd[0];
  endtask

  task automatic beginCmd();
    logic [7:0] rd;
    pinw(1'b0, 1'b0, 1'b0, rd);
    pinw(1'b1, 1'b0, 1'b0, rd);
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [7:0] field,
                         input int lead, output logic lastDo);
    logic d;
    beginCmd();
    for (int i = 0; i < lead; i++) clockBit(1'b0, d);
    clockBit(1'b1, d);
    for (int i = 1; i >= 0; i--) clockBit(op[i], d);
    for (int i = 7; i >= 0; i--) clockBit(field[i], d);
    lastDo = d;
  endtask

  task automatic readWord(input logic [6:0] a, input int lead,
                          output logic [15:0] w, output logic dummy);
    logic d;
    sendCmd(2'b10, {1'b0, a}, lead, dummy);
    for (int i = 15; i >= 0; i--) begin clockBit(1'b0, d); w[i] = d; end
  endtask

  task automatic checkRead(input string req, input logic [6:0] a);
    logic [15:0] w; logic dm;
    readWord(a, 0, w, dm);
    chk(req, {15'd0, dm}, 16'd0);
    chk(req, w, model[a]);
  endtask

  task automatic writeWord(input logic [6:0] a, input logic [15:0] v);
    logic d;
    sendCmd(2'b01, {1'b0, a}, 0, d);
    for (int i = 15; i >= 0; i--) clockBit(v[i], d);
    if (wen) model[a] = v;
  endtask

  task automatic eraseWord(input logic [6:0] a);
    logic d;
    sendCmd(2'b11, {1'b0, a}, 0, d);
    if (wen) model[a] = 16'hFFFF;
  endtask

  task automatic setWen(input bit on);
    logic d;
    sendCmd(2'b00, on ? 8'hC0 : 8'h00, 0, d);
    wen = on;
  endtask

  task automatic fillAll(input logic [15:0] v);
    logic d;
    sendCmd(2'b00, 8'h40, 0, d);
    for (int i = 15; i >= 0; i--) clockBit(v[i], d);
    if (wen) for (int i = 0; i < 128; i++) model[i] = v;
  endtask

  task automatic wipeAll();
    logic d;
    sendCmd(2'b00, 8'h80, 0, d);
    if (wen) for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual running expected finished");
      finishRun();
    end
  end

  initial begin
    logic [7:0] rd; logic [15:0] w; logic dm, d;
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 reset closed", {8'h0, rdData}, 16'h00FF);
    pulse(0, 8'h0A);
    chk("R1 one gate bit", {8'h0, rdData}, 16'h00FF);
    pulse(1, 8'h40);
    chk("R3 reset pin value", {8'h0, rdData}, 16'h0001);
    pulse(0, 8'h05);
    chk("R1 wrong enable closes", {8'h0, rdData}, 16'h00FF);
    pulse(0, 8'h0A); pulse(1, 8'h41);
    chk("R1 wrong unlock", {8'h0, rdData}, 16'h00FF);
    pulse(1, 8'h40);
    chk("R1 reopen", {8'h0, rdData}, 16'h0001);
    pulse(0, 8'h00);
    pinw(1'b1, 1'b1, 1'b1, rd);
    chk("R2 closed read", {8'h0, rd}, 16'h00FF);
    pulse(0, 8'h0A); pulse(1, 8'h40);
    chk("R2 write ignored", {8'h0, rdData}, 16'h0001);
    pinw(1'b0, 1'b0, 1'b0, rd); pulse(2, 8'h3C);
    chk("R3 other bits read back", {8'h0, rdData}, 16'h003D);

    readWord(7'd5, 0, w, dm);
    chk("R11 reset content", w, 16'hFFFF);
    chk("R7 dummy bit", {15'd0, dm}, 16'd0);

    sendCmd(2'b10, 8'h03, 0, dm);
    chk("R7 dummy before data", {15'd0, dm}, 16'd0);
    pinw(1'b1, 1'b0, 1'b0, rd);
    chk("R4 falling clock holds DO", {15'd0, rd[0]}, 16'd0);
    pinw(1'b1, 1'b0, 1'b0, rd);
    chk("R3 DO released", {8'h0, rd}, 16'h0081);

    writeWord(7'd7, 16'h1234);
    checkRead("R10 disabled write", 7'd7);
    setWen(1);
    writeWord(7'd7, 16'h1234); checkRead("R8 write", 7'd7);
    writeWord(7'd127, 16'hA5C3); checkRead("R8 last address", 7'd127);
    writeWord(7'd0, 16'h8001); checkRead("R8 first address", 7'd0);
    eraseWord(7'd7); checkRead("R9 erase", 7'd7);

    sendCmd(2'b01, 8'h09, 0, d);
    for (int i = 0; i < 8; i++) clockBit(1'b0, d);
    beginCmd();
    checkRead("R5 abort write", 7'd9);
    writeWord(7'd9, 16'h0F0F);
    readWord(7'd9, 3, w, dm);
    chk("R6 zero clocks in idle", w, 16'h0F0F);

    fillAll(16'hBEEF);
    checkRead("R9 write-all first", 7'd0);
    checkRead("R9 write-all mid", 7'd64);
    checkRead("R9 write-all last", 7'd127);
    wipeAll();
    checkRead("R9 erase-all first", 7'd0);
    checkRead("R9 erase-all last", 7'd127);
    writeWord(7'd4, 16'h5555);
    setWen(0);
    writeWord(7'd4, 16'h1111); checkRead("R10 disabled write", 7'd4);
    eraseWord(7'd4); checkRead("R10 disabled erase", 7'd4);
    wipeAll(); checkRead("R10 disabled erase-all", 7'd4);

    for (int n = 0; n < 60; n++) begin
      int op; logic [6:0] a; logic [15:0] v;
      op = $urandom % 6; a = 7'($urandom); v = 16'($urandom);
      case (op)
        0, 1: checkRead("R7 random read", a);
        2: writeWord(a, v);
        3: eraseWord(a);
        4: setWen(1);
        default: if (($urandom % 4) == 0) setWen(0); else writeWord(a, v);
      endcase
    end
    for (int i = 0; i < 128; i += 17) checkRead("R8 final sweep", 7'(i));

    done = 1;
    finishRun();
  end
endmodule